// File: doc/BRIEF.md
# UART Receive Interrupt and DMA Arbiter

This block sits between a UART's receive FIFO and the rest of the chip. From the software interrupt enables, a DMA-enable control, the FIFO fill state, a character-timeout event and the error flags of bytes going in and out of the FIFO, it drives one interrupt line, a code naming the most urgent pending source, the receive DMA request and a summary bit saying that some byte in the FIFO carries an error.

It keeps a count of the error-flagged bytes held in the FIFO. While that count is non-zero, receive DMA requests are held off. If DMA is enabled, an error interrupt is raised that no enable bit can mask, so that software drains the bad data by programmed reads. When the last flagged byte leaves the FIFO, DMA requests come back without any software action. Character timeout is its own interrupt source, separate from data-available, and any FIFO read clears it.

Top module: `uart_rx_irq_arb`

## Requirements
- R1: After reset `irq`=0, `iid`=4'b0001, `rx_dma_req`=0 and `lsr_err`=0, with the error count and the timeout flag cleared.
- R2: Each source is gated by its own bit of `irq_en`: bit0 data available, bit1 transmit empty, bit2 line status, bit3 modem status, bit4 character timeout. With a bit at 0 its source does not raise `irq`.
- R3: `iid` names the highest pending source, in this order and with these codes: line status 4'b0110, data available 4'b0100, character timeout 4'b1100, transmit empty 4'b0010, modem status 4'b0000; with nothing pending `iid`=4'b0001 and `irq`=0. `irq` is 1 whenever any source is pending.
- R4: A write with `push_err`=1 adds one to the error count, a read with `pop_err`=1 subtracts one (both in the same cycle leave it unchanged); the count changes at the clock edge and `lsr_err` is 1 exactly while the count is non-zero.
- R5: `rx_dma_req` = `dma_en` and trigger reached and not `lsr_err`, combinationally from the current inputs and state.
- R6: With `dma_en`=1 and `lsr_err`=1, `irq`=1 and `iid`=4'b0110 even when every `irq_en` bit is 0.
- R7: With `dma_en`=0, a non-zero error count alone never raises `irq`.
- R8: The line-status source from the FIFO head is pending only when `irq_en[2]`=1 and `head_err`=1.
- R9: In the cycle after the last flagged byte is read, with `dma_en`=1 and trigger reached, `rx_dma_req` is 1 again.
- R10: A `to_evt` pulse sets the timeout flag at the next edge; a `pop` clears it at the next edge and wins over a `to_evt` in the same cycle.
- R11: Trigger reached means `fifo_level` >= `trig_level`; the data-available source follows it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 5 | Interrupt enable bits (see R2) |
| dma_en | input | 1 | Receive DMA requests enabled |
| fifo_level | input | LVL_W | Bytes held in the receive FIFO |
| trig_level | input | LVL_W | Fill level that counts as trigger reached |
| push | input | 1 | A byte is written into the FIFO this cycle |
| push_err | input | 1 | The written byte carries an error |
| pop | input | 1 | A byte is read from the FIFO this cycle |
| pop_err | input | 1 | The read byte carries an error |
| head_err | input | 1 | The byte at the FIFO head carries an error |
| to_evt | input | 1 | Character-timeout event pulse |
| tx_empty | input | 1 | Transmit side is empty |
| modem_chg | input | 1 | Modem status changed |
| irq | output | 1 | Interrupt line |
| iid | output | 4 | Code of the highest pending source |
| rx_dma_req | output | 1 | Receive DMA request |
| lsr_err | output | 1 | Some FIFO byte carries an error |

## Verification
Directed cases try each source alone with its enable on and off, several sources at once to separate each priority level from the next, and the error count stepping up to two and back to zero with DMA on and off, which tells the unmaskable error interrupt apart from the head-of-FIFO line-status source. A timeout event coinciding with a read separates the clear-wins ordering from the set-wins one. Several thousand cycles of seeded random enables, levels, pushes and pops with errors then compare all four outputs every cycle against a bench model of the error count and timeout flag, which catches off-by-one trigger comparisons and wrong count updates on simultaneous read and write.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;

   localparam int N_SRC = 5;

   // source slots, index 0 is the most urgent
   localparam int SRC_LS  = 0;
   localparam int SRC_RDA = 1;
   localparam int SRC_TO  = 2;
   localparam int SRC_THR = 3;
   localparam int SRC_MS  = 4;

   // enable bit positions
   localparam int EN_RDA = 0;
   localparam int EN_THR = 1;
   localparam int EN_LS  = 2;
   localparam int EN_MS  = 3;
   localparam int EN_TO  = 4;

   typedef enum logic [3:0] {
      IID_MS   = 4'b0000,
      IID_NONE = 4'b0001,
      IID_THR  = 4'b0010,
      IID_RDA  = 4'b0100,
      IID_LS   = 4'b0110,
      IID_TO   = 4'b1100
   } iid_e;

   function automatic iid_e slot_code(input int idx);
      case (idx)
         SRC_LS:  return IID_LS;
         SRC_RDA: return IID_RDA;
         SRC_TO:  return IID_TO;
         SRC_THR: return IID_THR;
         default: return IID_MS;
      endcase
   endfunction

endpackage

// File: rtl/uart_rx_err_track.sv
module uart_rx_err_track #(
   parameter int DEPTH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic push_err,
   input  logic pop,
   input  logic pop_err,
   output logic err_any
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rx_err_track: DEPTH must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             inc, dec;

   assign inc = push & push_err;
   assign dec = pop & pop_err;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (inc && !dec)
         cnt_q <= cnt_q + CNT_W'(1);
      else if (dec && !inc)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign err_any = (cnt_q != '0);

   AST_ERR_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(DEPTH)) |-> !(inc && !dec)); // R4
   AST_ERR_NO_UNF: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> !(dec && !inc)); // R4
   AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |=> err_any); // R4

endmodule

// File: rtl/uart_rx_to_flag.sv
module uart_rx_to_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic to_evt,
   input  logic pop,
   output logic to_pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         to_pend <= 1'b0;
      else if (pop)
         to_pend <= 1'b0;
      else if (to_evt)
         to_pend <= 1'b1;
   end

   AST_TO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> !to_pend); // R10
   AST_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (to_evt && !pop) |=> to_pend); // R10

endmodule

// File: rtl/uart_rx_prio_enc.sv
module uart_rx_prio_enc
   import uart_rx_irq_pkg::*;
#(
   parameter int NS = N_SRC
) (
   input  logic [NS-1:0] req,
   output logic          any,
   output logic [3:0]    code
);
   if (NS < 1 || NS > N_SRC) begin : g_bad_ns
      $error("uart_rx_prio_enc: NS out of range");
   end

   logic [NS-1:0] win;

   for (genvar i = 0; i < NS; i++) begin : g_win
      if (i == 0) begin : g_top
         assign win[i] = req[i];
      end else begin : g_rest
         assign win[i] = req[i] & ~|req[i-1:0];
      end
   end

   always_comb begin
      logic [3:0] acc;
      acc = 4'b0000;
      for (int i = 0; i < NS; i++) begin
         if (win[i]) acc = acc | 4'(slot_code(i));
      end
      any  = |req;
      code = any ? acc : 4'(IID_NONE);
   end

   always_comb begin
      AST_ONE_WINNER: assert ($onehot0(win)); // R3
   end

endmodule

// File: rtl/uart_rx_irq_arb.sv
module uart_rx_irq_arb
   import uart_rx_irq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       irq_en,
   input  logic             dma_en,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [LVL_W-1:0] trig_level,
   input  logic             push,
   input  logic             push_err,
   input  logic             pop,
   input  logic             pop_err,
   input  logic             head_err,
   input  logic             to_evt,
   input  logic             tx_empty,
   input  logic             modem_chg,
   output logic             irq,
   output logic [3:0]       iid,
   output logic             rx_dma_req,
   output logic             lsr_err
);
   if (LVL_W < $clog2(DEPTH + 1)) begin : g_bad_lvl
      $error("uart_rx_irq_arb: LVL_W too narrow for DEPTH");
   end

   logic             err_any, to_pend, trig_hit;
   logic [N_SRC-1:0] src;

   uart_rx_err_track #(.DEPTH(DEPTH)) u_err (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_err(push_err),
      .pop(pop), .pop_err(pop_err),
      .err_any(err_any)
   );

   uart_rx_to_flag u_to (
      .clk(clk), .rst_n(rst_n),
      .to_evt(to_evt), .pop(pop),
      .to_pend(to_pend)
   );

   assign trig_hit = (fifo_level >= trig_level);

   always_comb begin
      src          = '0;
      src[SRC_LS]  = (irq_en[EN_LS] & head_err) | (dma_en & err_any);
      src[SRC_RDA] = irq_en[EN_RDA] & trig_hit;
      src[SRC_TO]  = irq_en[EN_TO] & to_pend;
      src[SRC_THR] = irq_en[EN_THR] & tx_empty;
      src[SRC_MS]  = irq_en[EN_MS] & modem_chg;
   end

   uart_rx_prio_enc #(.NS(N_SRC)) u_enc (
      .req(src), .any(irq), .code(iid)
   );

   assign lsr_err    = err_any;
   assign rx_dma_req = dma_en & trig_hit & ~err_any;

   AST_DMA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_err |-> !rx_dma_req); // R5
   AST_ERR_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && lsr_err) |-> (irq && iid == 4'(IID_LS))); // R6
   AST_DMA_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lsr_err) && dma_en && trig_hit) |-> rx_dma_req); // R9
   AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (iid == 4'(IID_NONE))); // R3
   AST_NO_DMA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !rx_dma_req); // R5

endmodule

// File: tb/uart_rx_irq_arb_bench.sv
`timescale 1ns/1ps
module uart_rx_irq_arb_bench;
   localparam int DEPTH = 16;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [4:0]       irq_en = '0;
   logic             dma_en = 1'b0;
   logic [LVL_W-1:0] fifo_level = '0;
   logic [LVL_W-1:0] trig_level = '0;
   logic             push = 0, push_err = 0, pop = 0, pop_err = 0;
   logic             head_err = 0, to_evt = 0, tx_empty = 0, modem_chg = 0;
   logic             irq, rx_dma_req, lsr_err;
   logic [3:0]       iid;

   int total = 0;
   int bad = 0;
   int m_cnt = 0;
   bit m_to = 0;
   bit done = 0;

   always #2 clk = ~clk;

   uart_rx_irq_arb #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_uart_rx_irq_arb (
      .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .dma_en(dma_en),
      .fifo_level(fifo_level), .trig_level(trig_level),
      .push(push), .push_err(push_err), .pop(pop), .pop_err(pop_err),
      .head_err(head_err), .to_evt(to_evt), .tx_empty(tx_empty),
      .modem_chg(modem_chg), .irq(irq), .iid(iid),
      .rx_dma_req(rx_dma_req), .lsr_err(lsr_err)
   );

   function automatic logic [3:0] exp_iid();
      bit trig = (fifo_level >= trig_level);
      bit err  = (m_cnt != 0);
      if ((irq_en[2] && head_err) || (dma_en && err)) return 4'b0110;
      if (irq_en[0] && trig)      return 4'b0100;
      if (irq_en[4] && m_to)      return 4'b1100;
      if (irq_en[1] && tx_empty)  return 4'b0010;
      if (irq_en[3] && modem_chg) return 4'b0000;
      return 4'b0001;
   endfunction

   function automatic bit exp_dma();
      return dma_en && (fifo_level >= trig_level) && (m_cnt == 0);
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic [3:0] e;
      e = exp_iid();
      chk(tag, "iid", int'(iid), int'(e));
      chk(tag, "irq", int'(irq), int'(e != 4'b0001));
      chk(tag, "dma", int'(rx_dma_req), int'(exp_dma()));
      chk(tag, "lsr_err", int'(lsr_err), int'(m_cnt != 0));
   endtask

   // check mid-cycle, advance one edge, update the model, return at negedge
   task automatic cyc(input string tag);
      #1;
      check_all(tag);
      @(posedge clk);
      if (!rst_n) begin
         m_cnt = 0; m_to = 0;
      end else begin
         if (push && push_err && !(pop && pop_err)) m_cnt++;
         else if (pop && pop_err && !(push && push_err)) m_cnt--;
         if (pop) m_to = 0;
         else if (to_evt) m_to = 1;
      end
      @(negedge clk);
      push = 0; push_err = 0; pop = 0; pop_err = 0; to_evt = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL WDOG run did not finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      cyc("R1");
      rst_n = 1'b1;
      cyc("R1");

      // R11 / R5: trigger boundary
      dma_en = 1; irq_en = 5'b00001;
      fifo_level = 8; trig_level = 8; cyc("R11");
      fifo_level = 7; cyc("R11");
      fifo_level = 9; cyc("R5");

      // R2: all sources active, all enables off
      dma_en = 0; irq_en = 5'b00000; tx_empty = 1; modem_chg = 1; head_err = 1;
      to_evt = 1; cyc("R2");
      cyc("R2");
      irq_en = 5'b01000; cyc("R2");
      irq_en = 5'b10000; cyc("R2");
      tx_empty = 0; modem_chg = 0; head_err = 0;

      // R7: errored byte with DMA off
      irq_en = 5'b00000; pop = 1; cyc("R10");
      push = 1; push_err = 1; cyc("R4");
      cyc("R7");
      // R6: DMA on, no enables
      dma_en = 1; cyc("R6");
      // R8: DMA off, head error gating
      dma_en = 0; irq_en = 5'b00100; cyc("R8");
      head_err = 1; cyc("R8");
      head_err = 0;

      // R9: two flagged bytes, drain one by one
      dma_en = 1; irq_en = 5'b00000; fifo_level = 10; trig_level = 4;
      push = 1; push_err = 1; cyc("R4");
      pop = 1; pop_err = 1; cyc("R9");
      pop = 1; pop_err = 1; cyc("R9");
      cyc("R9");
      push = 1; push_err = 1; pop = 1; pop_err = 1; cyc("R4");

      // R10: timeout set, pop clears, pop wins over event
      irq_en = 5'b10000; dma_en = 0; to_evt = 1; cyc("R10");
      cyc("R10");
      to_evt = 1; pop = 1; cyc("R10");
      cyc("R10");

      // R3: priority ladder
      irq_en = 5'b11111; tx_empty = 1; modem_chg = 1; head_err = 1; to_evt = 1;
      fifo_level = 10; trig_level = 4; cyc("R3");
      head_err = 0; cyc("R3");
      fifo_level = 2; cyc("R3");
      pop = 1; cyc("R3");
      tx_empty = 0; cyc("R3");
      modem_chg = 0; cyc("R3");

      // seeded random stimulus
      for (int n = 0; n < 4000; n++) begin
         irq_en     = 5'($urandom);
         dma_en     = 1'($urandom);
         fifo_level = LVL_W'($urandom_range(0, DEPTH));
         trig_level = LVL_W'($urandom_range(0, DEPTH));
         head_err   = ($urandom_range(0, 3) == 0);
         tx_empty   = 1'($urandom);
         modem_chg  = ($urandom_range(0, 3) == 0);
         to_evt     = ($urandom_range(0, 5) == 0);
         push       = 1'($urandom);
         push_err   = push && (m_cnt < DEPTH - 1) && ($urandom_range(0, 2) == 0);
         pop        = 1'($urandom);
         pop_err    = pop && (m_cnt > 0) && ($urandom_range(0, 1) == 0);
         if (n % 500 == 250) begin
            rst_n = 0;
            cyc("R1");
            rst_n = 1;
         end else begin
            cyc("RND R3 R4 R5 R10");
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule